// File: doc/BRIEF.md
# Serial Frame Transmit Front End

This block takes bytes that software writes into a three-entry queue and sends them out one bit at a time on a serial line. A single status byte carries the control bits that software sets and the flags that hardware reports. An external bit-rate strobe paces the line. Each strobe moves the output on by one bit, least significant bit first. The driver-enable output is active low and is low only while bits are being sent.

Software opens a frame by setting the enable bit, which also flushes the queue and clears the previous frame's flags. It then feeds bytes. The frame runs as long as the queue refills before each byte finishes. When the queue is found empty at a byte boundary, the frame ends and hardware drops the enable. If an acknowledge check is requested, hardware first waits a programmable number of bit times and reports either done or no-acknowledge. A collision input ends the frame early and bumps a counter, unless the counter is in slot mode, where it simply holds the value software loaded. Clearing the enable mid-frame aborts the frame and leaves the line high. The interrupt output follows queue space in normal mode and frame completion or underrun in DMA-select mode.

Top module: `sertx_ctrl`

## Requirements
- R1: The queue holds 3 bytes. Status bit 2 (space flag) is 1 whenever fewer than 3 bytes are queued. A byte write while 3 bytes are queued is dropped and never reaches the line.
- R2: Writing the control byte with bit 1 (enable) = 1 while the enable is clear empties the queue and clears status bits 3 (done), 4 (collision), 5 (underrun) and 6 (no-acknowledge). Software writes set bit 0 (DMA select), bit 1 and bit 7 (acknowledge check). The collision counter keeps its value across this write.
- R3: With the enable set and the shifter idle, a queued byte is loaded on the next clock. Its bit 0 appears on txd and den goes low in the cycle after the load. Each clock that samples bit_tick high advances txd to the next bit.
- R4: If the queue is not empty when the eighth bit's tick arrives, the next byte follows with no idle gap and den stays low.
- R5: If the queue is empty at the eighth bit's tick and the acknowledge check is off, the frame ends on that clock: the enable clears, done sets, and txd and den return high.
- R6: Clearing the enable by a control write during a frame makes txd and den high from the second clock after the write. They stay high under further ticks, and done is not set.
- R7: A collision input sampled high while bits are being sent ends the frame on that clock. The enable clears, the collision flag sets, and in count mode the collision counter increments.
- R8: A counter write loads the collision counter. With slot_mode high, collisions leave the counter unchanged.
- R9: With the acknowledge check on, the enable stays set after the last bit while ifs_len further ticks are counted. On the clock after the count reaches zero, the enable clears. Done sets if ack_in was seen during the wait; otherwise no-acknowledge sets and done stays clear.
- R10: irq equals the space flag when DMA select is 0, and equals done OR underrun when DMA select is 1.
- R11: With DMA select 1, a byte write while done is set or during the acknowledge wait sets the underrun flag. With DMA select 0, the underrun flag never sets.
- R12: While the enable is clear and no frame is in progress, txd and den are high regardless of bit_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_wr | input | 1 | Byte write strobe into the queue |
| byte_data | input | 8 | Byte to queue |
| ctl_wr | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control value: bit 0 DMA select, bit 1 enable, bit 7 acknowledge check |
| status | output | 8 | {ackchk, noack, urun, coll, done, space, enable, dma} |
| slot_mode | input | 1 | 1: counter holds a slot limit and is not incremented |
| cnt_wr | input | 1 | Collision counter write strobe |
| cnt_data | input | 8 | Value for the collision counter |
| coll_count | output | 8 | Collision counter |
| ifs_len | input | 4 | Acknowledge wait length in bit times |
| bit_tick | input | 1 | Bit-rate clock enable |
| coll_in | input | 1 | Collision detected |
| ack_in | input | 1 | Acknowledge received |
| txd | output | 1 | Serial data out, idles high |
| den | output | 1 | Driver enable, active low |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check that the line is high whenever the driver is off, and that a fresh enable starts with clean flags and room in the queue. They also check that the line is high one cycle after any loss of enable, that a collision or no-acknowledge never leaves the enable set, and that underrun cannot appear in normal mode. Only the bench's scenarios can show the bit order and pacing, the dropped fifth byte of an overfilled queue, the acknowledge window length, and the counter behaviour in both modes.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int ST_DMA    = 0;
    localparam int ST_EN     = 1;
    localparam int ST_SPACE  = 2;
    localparam int ST_DONE   = 3;
    localparam int ST_COLL   = 4;
    localparam int ST_URUN   = 5;
    localparam int ST_NOACK  = 6;
    localparam int ST_ACKCHK = 7;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_WAIT  = 2'd2
    } ser_state_e;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
    parameter int DEPTH = 3,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_s;

    fifo_s q, d;
    logic  do_push, do_pop;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (clr) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = wdata;
                d.wp        = next_ptr(q.wp);
            end
            if (do_pop) begin
                d.rp = next_ptr(q.rp);
            end
            if (do_push && !do_pop) begin
                d.cnt = q.cnt + CW'(1);
            end else if (do_pop && !do_push) begin
                d.cnt = q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.mem[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == CW'(DEPTH));
endmodule

// File: rtl/sertx_serial.sv
module sertx_serial
    import sertx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IFS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ack_chk,
    input  logic [IFS_W-1:0] ifs_len,
    input  logic             bit_tick,
    input  logic             coll_in,
    input  logic             ack_in,
    input  logic             fifo_empty,
    input  logic [DW-1:0]    fifo_rdata,
    output logic             pop,
    output logic             txd,
    output logic             den,
    output logic             ev_done,
    output logic             ev_noack,
    output logic             ev_coll,
    output logic             in_wait
);
    localparam int BW = $clog2(DW + 1);

    typedef struct packed {
        ser_state_e       state;
        logic [DW-1:0]    sh;
        logic [BW-1:0]    left;
        logic [IFS_W-1:0] ifs;
        logic             seen;
    } ser_s;

    ser_s q, d;
    logic seen_now;

    always_comb begin
        d        = q;
        pop      = 1'b0;
        ev_done  = 1'b0;
        ev_noack = 1'b0;
        ev_coll  = 1'b0;
        seen_now = q.seen | ack_in;
        unique case (q.state)
            SER_IDLE: begin
                if (en && !fifo_empty) begin
                    pop     = 1'b1;
                    d.sh    = fifo_rdata;
                    d.left  = BW'(DW);
                    d.state = SER_SHIFT;
                end
            end
            SER_SHIFT: begin
                if (!en) begin
                    d.state = SER_IDLE;
                end else if (coll_in) begin
                    ev_coll = 1'b1;
                    d.state = SER_IDLE;
                end else if (bit_tick) begin
                    if (q.left == BW'(1)) begin
                        if (!fifo_empty) begin
                            pop    = 1'b1;
                            d.sh   = fifo_rdata;
                            d.left = BW'(DW);
                        end else if (ack_chk) begin
                            d.state = SER_WAIT;
                            d.ifs   = ifs_len;
                            d.seen  = 1'b0;
                        end else begin
                            ev_done = 1'b1;
                            d.state = SER_IDLE;
                        end
                    end else begin
                        d.sh   = q.sh >> 1;
                        d.left = q.left - BW'(1);
                    end
                end
            end
            SER_WAIT: begin
                if (!en) begin
                    d.state = SER_IDLE;
                end else begin
                    d.seen = seen_now;
                    if (q.ifs == '0) begin
                        ev_done  = seen_now;
                        ev_noack = !seen_now;
                        d.state  = SER_IDLE;
                    end else if (bit_tick) begin
                        d.ifs = q.ifs - IFS_W'(1);
                    end
                end
            end
            default: d.state = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: SER_IDLE, sh: '0, left: '0, ifs: '0, seen: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign txd     = (q.state == SER_SHIFT) ? q.sh[0] : 1'b1;
    assign den     = (q.state != SER_SHIFT);
    assign in_wait = (q.state == SER_WAIT);
endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int DEPTH = 3,
    parameter int DW    = 8,
    parameter int CNT_W = 8,
    parameter int IFS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_wr,
    input  logic [DW-1:0]    byte_data,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_data,
    output logic [7:0]       status,
    input  logic             slot_mode,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_data,
    output logic [CNT_W-1:0] coll_count,
    input  logic [IFS_W-1:0] ifs_len,
    input  logic             bit_tick,
    input  logic             coll_in,
    input  logic             ack_in,
    output logic             txd,
    output logic             den,
    output logic             irq
);
    typedef struct packed {
        logic             dma;
        logic             en;
        logic             ackchk;
        logic             done;
        logic             coll;
        logic             urun;
        logic             noack;
        logic [CNT_W-1:0] cnt;
    } ctl_s;

    ctl_s q, d;

    logic          fifo_clr, fifo_pop, fifo_empty, fifo_full;
    logic [DW-1:0] fifo_rdata;
    logic          ev_done, ev_noack, ev_coll, in_wait;
    logic          unused_ctl;

    assign unused_ctl = ^ctl_data[6:2];

    sertx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (byte_wr),
        .wdata (byte_data),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    sertx_serial #(.DW(DW), .IFS_W(IFS_W)) u_serial (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (q.en),
        .ack_chk    (q.ackchk),
        .ifs_len    (ifs_len),
        .bit_tick   (bit_tick),
        .coll_in    (coll_in),
        .ack_in     (ack_in),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .pop        (fifo_pop),
        .txd        (txd),
        .den        (den),
        .ev_done    (ev_done),
        .ev_noack   (ev_noack),
        .ev_coll    (ev_coll),
        .in_wait    (in_wait)
    );

    always_comb begin
        d        = q;
        fifo_clr = 1'b0;
        if (ev_done) begin
            d.en   = 1'b0;
            d.done = 1'b1;
        end
        if (ev_noack) begin
            d.en    = 1'b0;
            d.noack = 1'b1;
        end
        if (ev_coll) begin
            d.en   = 1'b0;
            d.coll = 1'b1;
            if (!slot_mode) begin
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
        if (byte_wr && q.dma && (q.done || in_wait)) begin
            d.urun = 1'b1;
        end
        if (ctl_wr) begin
            d.dma    = ctl_data[ST_DMA];
            d.en     = ctl_data[ST_EN];
            d.ackchk = ctl_data[ST_ACKCHK];
            if (ctl_data[ST_EN] && !q.en) begin
                fifo_clr = 1'b1;
                d.done   = 1'b0;
                d.coll   = 1'b0;
                d.urun   = 1'b0;
                d.noack  = 1'b0;
            end
        end
        if (cnt_wr) begin
            d.cnt = cnt_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        status              = '0;
        status[ST_DMA]      = q.dma;
        status[ST_EN]       = q.en;
        status[ST_SPACE]    = !fifo_full;
        status[ST_DONE]     = q.done;
        status[ST_COLL]     = q.coll;
        status[ST_URUN]     = q.urun;
        status[ST_NOACK]    = q.noack;
        status[ST_ACKCHK]   = q.ackchk;
    end

    assign coll_count = q.cnt;
    assign irq        = q.dma ? (q.done | q.urun) : !fifo_full;
endmodule

// File: rtl/sertx_ctrl_chk.sv
module sertx_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic       txd,
    input logic       den
);
    // R12: driver off means the line is high
    a_r12_line_high_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        den |-> txd);

    // R2: a new enable starts with an empty queue and clean flags
    a_r2_enable_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> (status[2] && !status[3] && !status[4] && !status[5] && !status[6]));

    // R6: any loss of enable leaves the line high on the following cycle
    a_r6_abort_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[1]) |=> (txd && den));

    // R7: a collision never leaves the enable set
    a_r7_coll_drops_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> !status[1]);

    // R9: no-acknowledge excludes done and ends the frame
    a_r9_noack_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> (!status[3] && !status[1]));

    // R11: underrun cannot arise in normal mode
    a_r11_no_urun_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && !status[5]) |=> !status[5]);
endmodule

bind sertx_ctrl sertx_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status),
    .txd    (txd),
    .den    (den)
);

// File: tb/sertx_ctrl_test.sv
module sertx_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_wr = 1'b0;
    logic [7:0] byte_data = '0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = '0;
    logic [7:0] status;
    logic       slot_mode = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_data = '0;
    logic [7:0] coll_count;
    logic [3:0] ifs_len = 4'd3;
    logic       bit_tick = 1'b0;
    logic       coll_in = 1'b0;
    logic       ack_in = 1'b0;
    logic       txd, den, irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sertx_ctrl uut (
        .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .byte_data(byte_data),
        .ctl_wr(ctl_wr), .ctl_data(ctl_data), .status(status),
        .slot_mode(slot_mode), .cnt_wr(cnt_wr), .cnt_data(cnt_data),
        .coll_count(coll_count), .ifs_len(ifs_len), .bit_tick(bit_tick),
        .coll_in(coll_in), .ack_in(ack_in), .txd(txd), .den(den), .irq(irq)
    );

    // {dma, byte}
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h01},
        {1'b1, 8'h80}, {1'b0, 8'hFF}, {1'b1, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); byte_wr = 1'b1; byte_data = b;
        @(negedge clk); byte_wr = 1'b0;
    endtask

    task automatic ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_data = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic setcnt(input logic [7:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_data = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0;
    endtask

    task automatic coll_pulse();
        @(negedge clk); coll_in = 1'b1;
        @(negedge clk); coll_in = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk); ack_in = 1'b1;
        @(negedge clk); ack_in = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b);
        b[0] = txd;
        for (int i = 1; i < 8; i++) begin
            tick();
            b[i] = txd;
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // reset state
        chk("R1 reset status", status, 8'h04);
        chk("R12 reset line", {txd, den}, 2'b11);
        chk("R10 reset irq", irq, 1'b1);
        chk("R8 reset count", coll_count, 8'h00);
        tick();
        chk("R12 idle tick", {txd, den}, 2'b11);

        // table of single-byte frames
        for (int v = 0; v < 6; v++) begin
            ctl({6'b0, 1'b1, VEC[v][8]});
            chk("R10 irq after enable", irq, !VEC[v][8]);
            put(VEC[v][7:0]);
            cyc(1);
            chk("R3 den low", den, 1'b0);
            recv(rx);
            chk("R3 byte LSB first", rx, VEC[v][7:0]);
            tick();
            chk("R5 done, enable clear", {status[3], status[1]}, 2'b10);
            chk("R5 line idle", {txd, den}, 2'b11);
            chk("R10 irq after frame", irq, 1'b1);
        end

        // R1 / R4: overfill and back-to-back
        ctl(8'h02);
        put(8'h11);
        cyc(1);
        put(8'h22); put(8'h33); put(8'h44);
        chk("R1 space flag when full", status[2], 1'b0);
        put(8'h55);
        recv(rx); chk("R4 byte 1", rx, 8'h11);
        tick(); chk("R4 no gap", den, 1'b0);
        chk("R1 space after pop", status[2], 1'b1);
        recv(rx); chk("R4 byte 2", rx, 8'h22);
        tick(); recv(rx); chk("R4 byte 3", rx, 8'h33);
        tick(); recv(rx); chk("R4 byte 4", rx, 8'h44);
        tick();
        chk("R1 fifth byte dropped", {den, status[3]}, 2'b11);

        // R6 abort
        ctl(8'h02);
        put(8'h00);
        cyc(1);
        tick();
        chk("R6 line low mid frame", txd, 1'b0);
        ctl(8'h00);
        cyc(1);
        chk("R6 abort high", {txd, den}, 2'b11);
        tick(); tick();
        chk("R6 stays high", {txd, den, status[3]}, 3'b110);

        // R2 enable flushes queue
        put(8'h81); put(8'h82);
        ctl(8'h02);
        cyc(3);
        chk("R2 queue flushed", den, 1'b1);

        // R7 collisions in count mode
        setcnt(8'h00);
        ctl(8'h00);
        ctl(8'h02);
        put(8'h0F);
        cyc(1);
        tick();
        coll_pulse();
        chk("R7 coll flag, enable clear", {status[4], status[1], status[3]}, 3'b100);
        chk("R7 line high", {txd, den}, 2'b11);
        chk("R7 count 1", coll_count, 8'h01);
        ctl(8'h02);
        chk("R2 coll flag cleared", status[4], 1'b0);
        put(8'h0F);
        cyc(1);
        coll_pulse();
        chk("R7 count 2", coll_count, 8'h02);
        setcnt(8'h00);
        chk("R8 software clear", coll_count, 8'h00);

        // R8 slot mode
        slot_mode = 1'b1;
        setcnt(8'h05);
        ctl(8'h02);
        put(8'hF0);
        cyc(1);
        coll_pulse();
        chk("R8 slot count held", coll_count, 8'h05);
        chk("R8 coll still flagged", status[4], 1'b1);
        slot_mode = 1'b0;

        // R9 acknowledge wait, ack seen
        ifs_len = 4'd3;
        ctl(8'h82);
        put(8'hA1);
        cyc(1);
        recv(rx);
        tick();
        chk("R9 waiting, enable held", {status[3], status[1]}, 2'b01);
        chk("R9 line idle in wait", {txd, den}, 2'b11);
        tick();
        ack_pulse();
        tick(); tick();
        chk("R9 still waiting", {status[3], status[1]}, 2'b01);
        cyc(1);
        chk("R9 done with ack", {status[6], status[3], status[1]}, 3'b010);

        // R9 no acknowledge
        ctl(8'h00);
        ctl(8'h82);
        put(8'hA2);
        cyc(1);
        recv(rx);
        tick(); tick(); tick(); tick();
        cyc(1);
        chk("R9 noack", {status[6], status[3], status[1]}, 3'b100);

        // R11 underrun in DMA mode
        ctl(8'h03);
        put(8'h5A);
        cyc(1);
        recv(rx);
        tick();
        chk("R11 no underrun yet", status[5], 1'b0);
        chk("R10 dma irq on done", irq, 1'b1);
        put(8'h77);
        chk("R11 underrun late write", status[5], 1'b1);
        ctl(8'h03);
        chk("R10 dma irq clear", {irq, status[5]}, 2'b00);
        ctl(8'h00);

        // R11 normal mode never underruns
        ctl(8'h02);
        put(8'h5A);
        cyc(1);
        recv(rx);
        tick();
        put(8'h77);
        chk("R11 normal no underrun", status[5], 1'b0);
        chk("R10 normal irq space", irq, status[2]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule